// File: doc/BRIEF.md
# Prescaled One-Shot Countdown Timer

This block is the countdown timer of a local interrupt controller. Software programs a 3-bit divide code and then writes a 32-bit start value. The block counts that value down once per prescaler period. When the count reaches zero it raises a one-cycle expiry pulse and then stops. A read of the current-count register returns the number of prescaler periods still to run, rounded up.

The prescaler is a free-running phase counter that is cleared by reset and advances on every clock. A prescaler edge is a cycle in which the phase is a multiple of the divide ratio. A start value written in the middle of a prescaler period first waits for the next prescaler edge, and only then starts counting its full programmed number of periods.

All register accesses use one strobe, a 2-bit register select, write data and a combinational read-data output. Select 0 is the start-value register, select 1 the current count, select 2 the divide configuration, and select 3 is unused.

Top module: `oneshot_cdtimer`

## Requirements
- R1: The divide ratio is 2^e, where e = ({code[3], code[1:0]} + 1) mod 8. A code with bits 3, 1 and 0 all set gives a ratio of 1. Code 0 gives a ratio of 2.
- R2: A write to select 2 keeps only bits 3, 1 and 0 of the data. A read of select 2 returns those bits in their places and zero in every other bit.
- R3: Let a start value N > 0 be written on an edge where the phase counter is a multiple of the ratio D. The expiry pulse is then visible in the cycle after the edge that lies N×D clocks after the write edge.
- R4: Let the write edge fall at phase p with r = p mod D and r ≠ 0. Expiry then comes (D − r) + N×D clocks after the write edge. The phase is 0 after the first edge out of reset and grows by 1 on each later edge.
- R5: While a countdown runs, a read of select 1 returns the remaining clocks to expiry divided by D, rounded up.
- R6: A read of select 1 returns 0 when no countdown is active, including after expiry.
- R7: A write to select 1 changes neither the readback nor the expiry time.
- R8: Expiry is a pulse exactly one cycle wide. After it the timer stays idle and gives no further pulse until the next start-value write.
- R9: Writing a start value of 0 stops a running countdown. No expiry pulse follows.
- R10: A start-value write during a countdown restarts the countdown from the new value. This holds even on the edge where the old countdown would have expired, and no pulse is given for the old run.
- R11: A synchronous active-high reset clears the count, the running state, the divide code, the stored start value and the expiry output.
- R12: A read of select 0 returns the start value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_addr | input | 2 | Register select: 0 start value, 1 current count, 2 divide code |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| expire | output | 1 | One-cycle pulse when the countdown reaches zero |

## Verification
The decrement that would take the count to zero can fall on the same edge as a new start-value write. The bench provokes this by writing a fresh value on exactly the edge where the running countdown is due to expire. It then requires that no pulse appears for the old run, and that the readback and the expiry of the new run follow the timing computed from the phase at that edge. A write to the read-only current-count register is also placed inside running countdowns. There the readback must track the model on every cycle and the expiry must arrive on time.

// File: rtl/octmr_pkg.sv
package octmr_pkg;
  localparam int CODE_W  = 3;
  localparam int PHASE_W = (1 << CODE_W) - 1;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_NOW   = 2'd1,
    SEL_DIV   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Exponent of the divide ratio; the increment wraps modulo 8.
  function automatic logic [CODE_W-1:0] ratio_exp(input logic [CODE_W-1:0] code);
    return code + CODE_W'(1);
  endfunction

  // Gather the scattered code bits {3,1,0} from a written word.
  function automatic logic [CODE_W-1:0] pack_code(input logic [31:0] w);
    return {w[3], w[1:0]};
  endfunction

  // Periods still to run, rounded up; saturates at all ones.
  function automatic logic [31:0] periods_left(input logic [31:0] cnt, input logic pend);
    if (pend && (&cnt)) return '1;
    return cnt + {31'd0, pend};
  endfunction
endpackage

// File: rtl/octmr_divcfg.sv
module octmr_divcfg
  import octmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [31:0]        wdata,
  output logic [PHASE_W-1:0] phase_mask,
  output logic [31:0]        readback
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] expo;

  always_ff @(posedge clk) begin
    if (rst)     code_q <= '0;
    else if (wr) code_q <= pack_code(wdata);
  end

  assign expo = ratio_exp(code_q);

  for (genvar i = 0; i < PHASE_W; i++) begin : g_mask
    assign phase_mask[i] = (CODE_W'(i) < expo);
  end

  assign readback = {28'd0, code_q[2], 1'b0, code_q[1:0]};
endmodule

// File: rtl/octmr_prescaler.sv
module octmr_prescaler
  import octmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_mask,
  output logic               tick
);
  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + PHASE_W'(1);
  end

  assign tick = ((phase_q & phase_mask) == '0);
endmodule

// File: rtl/octmr_core.sv
module octmr_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             pend,
  output logic             expire,
  output logic [CNT_W-1:0] start_val
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, start_q;
  logic             run_q, pend_q, exp_q;
  logic             nonzero;

  assign nonzero = |load_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      start_q <= '0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      exp_q   <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (load) begin
        start_q <= load_val;
        cnt_q   <= load_val;
        run_q   <= nonzero;
        pend_q  <= nonzero && !tick;
      end else if (run_q && tick) begin
        if (pend_q) begin
          pend_q <= 1'b0;
        end else if (cnt_q == ONE) begin
          cnt_q <= '0;
          run_q <= 1'b0;
          exp_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign cnt       = cnt_q;
  assign running   = run_q;
  assign pend      = pend_q;
  assign expire    = exp_q;
  assign start_val = start_q;
endmodule

// File: rtl/oneshot_cdtimer.sv
module oneshot_cdtimer
  import octmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        expire
);
  logic               load_w, divwr_w, tick_w, run_w, pend_w;
  logic [31:0]        cnt_w, start_w, div_rb_w;
  logic [PHASE_W-1:0] mask_w;

  assign load_w  = reg_wr && (reg_addr == SEL_START);
  assign divwr_w = reg_wr && (reg_addr == SEL_DIV);

  octmr_divcfg u_div (
    .clk(clk), .rst(rst), .wr(divwr_w), .wdata(reg_wdata),
    .phase_mask(mask_w), .readback(div_rb_w)
  );

  octmr_prescaler u_pre (
    .clk(clk), .rst(rst), .phase_mask(mask_w), .tick(tick_w)
  );

  octmr_core #(.CNT_W(32)) u_core (
    .clk(clk), .rst(rst), .load(load_w), .load_val(reg_wdata), .tick(tick_w),
    .cnt(cnt_w), .running(run_w), .pend(pend_w), .expire(expire),
    .start_val(start_w)
  );

  always_comb begin
    unique case (reg_addr)
      SEL_START: reg_rdata = start_w;
      SEL_NOW:   reg_rdata = run_w ? periods_left(cnt_w, pend_w) : 32'd0;
      SEL_DIV:   reg_rdata = div_rb_w;
      default:   reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/oneshot_cdtimer_chk.sv
module oneshot_cdtimer_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        expire,
  input logic        tick,
  input logic        load,
  input logic        running,
  input logic [31:0] cnt
);
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);

  a_r8_idle_after: assert property (@(posedge clk) disable iff (rst)
    expire |-> !running);

  a_r3_expire_from_one: assert property (@(posedge clk) disable iff (rst)
    expire |-> ($past(cnt) == 32'd1 && $past(tick)));

  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt));

  a_r7_now_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd1 && !tick) |=> $stable(cnt));

  a_r9_zero_stops: assert property (@(posedge clk) disable iff (rst)
    (load && reg_wdata == 32'd0) |=> (!running && !expire));

  a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> !expire);

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!running && !expire && cnt == 32'd0));
endmodule

bind oneshot_cdtimer oneshot_cdtimer_chk chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .expire(expire), .tick(tick_w), .load(load_w),
  .running(run_w), .cnt(cnt_w)
);

// File: tb/oneshot_cdtimer_tb_top.sv
`timescale 1ns/1ps
module oneshot_cdtimer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd1;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        expire;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  oneshot_cdtimer dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .expire(expire)
  );

  // Phase model: 0 after the first edge out of reset, +1 on each edge (R4).
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // R1: ratio from the divide code, written as a table over the packed code.
  function automatic int ratio_of(input logic [31:0] code);
    case ({code[3], code[1:0]})
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 16;
      3'd4: return 32;
      3'd5: return 64;
      3'd6: return 128;
      default: return 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
    reg_addr = 2'd1;
    #1;
  endtask

  // Start a countdown; returns the expected delay in clocks (R3, R4).
  task automatic start(input int n, input int d, output int k_exp);
    int r;
    r = cyc % d;
    k_exp = n * d + ((r != 0) ? (d - r) : 0);
    reg_write(2'd0, 32'(n));
  endtask

  // Follows a run cycle by cycle from k = 0 (negedge after write edge) to kend.
  task automatic watch(input int k_exp, input int d, input int kend,
                       input int inj_k, input bit idle, input string tag);
    int bad = 0;
    longint act_rd = 0, exp_rd = 0;
    for (int k = 0; k <= kend; k++) begin
      bit pulse;
      longint want;
      reg_wr = 1'b0; reg_addr = 2'd1;
      #1;
      pulse = idle ? 1'b0 : (k == k_exp);
      want  = (idle || k >= k_exp) ? 0 : ((k_exp - k) + d - 1) / d;
      if (expire !== pulse || longint'(reg_rdata) != want) begin
        if (bad == 0) begin act_rd = reg_rdata; exp_rd = want; end
        bad++;
      end
      if (k < kend) begin
        if (k == inj_k) begin
          reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = $urandom;
        end
        @(negedge clk);
      end
    end
    reg_wr = 1'b0;
    check(bad == 0, tag, "pulse/readback track", act_rd, exp_rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R0 watchdog expired: actual 1 expected 0");
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int k, k2, d, n;
    void'($urandom(32'd7731));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    reg_read(2'd0, v); check(v == 0, "R11", "start value after reset", v, 0);
    reg_read(2'd1, v); check(v == 0, "R11", "count after reset", v, 0);
    reg_read(2'd2, v); check(v == 0, "R11", "divide code after reset", v, 0);
    check(expire == 1'b0, "R11", "expire after reset", expire, 0);

    // R2 mask of divide code
    reg_write(2'd2, 32'hFFFF_FFF4); reg_read(2'd2, v); check(v == 32'h0, "R2", "mask F4", v, 0);
    reg_write(2'd2, 32'hFFFF_FFFF); reg_read(2'd2, v); check(v == 32'hB, "R2", "mask FF", v, 11);
    reg_write(2'd2, 32'h0000_0005); reg_read(2'd2, v); check(v == 32'h1, "R2", "mask 05", v, 1);

    // R1 R3 ratio 1, count 1
    reg_write(2'd2, 32'hB);
    start(1, 1, k); watch(k, 1, k + 4, -1, 1'b0, "R1 R3 R8 ratio1");

    // R4 misaligned write, ratio 4
    reg_write(2'd2, 32'h1);
    while (cyc % 4 != 1) @(negedge clk);
    start(2, 4, k);
    check(k == 11, "R4", "model delay", k, 11);
    watch(k, 4, k + 6, -1, 1'b0, "R4 R5 R6");

    // R12 start value readback
    reg_read(2'd0, v); check(v == 2, "R12", "start value", v, 2);

    // R7 write to current count inside a run
    reg_write(2'd2, 32'h0);
    start(5, 2, k); watch(k, 2, k + 3, 3, 1'b0, "R7 R5");

    // R9 stop by zero
    start(9, 2, k); watch(k, 2, 4, -1, 1'b0, "R9 pre");
    reg_write(2'd0, 32'd0);
    watch(0, 2, 50, -1, 1'b1, "R9 R6 stopped");
    reg_read(2'd0, v); check(v == 0, "R12", "zero start value", v, 0);

    // R10 restart on the expiry edge
    reg_write(2'd2, 32'h0);
    start(4, 2, k); watch(k, 2, k - 1, -1, 1'b0, "R10 first run");
    start(3, 2, k2); watch(k2, 2, k2 + 4, -1, 1'b0, "R10 after restart on expiry edge");

    // R10 restart mid-run, ratio 8
    reg_write(2'd2, 32'h2);
    start(6, 8, k); watch(k, 8, 13, -1, 1'b0, "R10 mid pre");
    start(2, 8, k2); watch(k2, 8, k2 + 3, -1, 1'b0, "R10 mid restart");

    // R1 R3 R4 R5 R8 random runs over codes, counts and phases
    for (int i = 0; i < 24; i++) begin
      logic [31:0] code;
      int idle_n, inj;
      code = $urandom & 32'hF;
      d = ratio_of(code);
      n = 1 + ($urandom % 12);
      idle_n = $urandom % 8;
      reg_write(2'd2, code);
      repeat (idle_n) @(negedge clk);
      start(n, d, k);
      inj = ($urandom % 2 == 0) ? int'($urandom % k) : -1;
      watch(k, d, k + 3, inj, 1'b0, "R1 R3 R4 R5 R7 R8 random");
    end

    done = 1'b1;
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule